// File: doc/BRIEF.md
# Sub-cycle dithered PWM generator

The block makes a pulse-width modulated waveform with 8-bit average resolution and twice the ripple frequency of a plain 256-step PWM. Each 256-clock period is cut into two 128-clock sub-cycles. The upper seven bits of the duty value set a coarse high time that both sub-cycles share. The lowest bit adds one extra high clock, and only to sub-cycle 0. Across the two sub-cycles the total high time is therefore the full 8-bit duty value, but the energy is spread over two shorter pulses.

Software writes a duty value through a one-cycle write strobe. The value waits in a shadow register and becomes active only when a new full period starts. The waveform reaches the pin through a small pin multiplexer. A function-select input chooses PWM or general I/O. A direction input turns the output driver on or off. A data bit acts as the on/off gate in PWM mode and as the driven level in I/O mode.

Top module: `subcycle_pwm`

## Requirements
- R1: After reset the period counter starts at 0 and advances by one on every clock, wrapping after 256 clocks. It keeps running whatever the pin controls are. Count bit 7 selects the sub-cycle (0 or 1) and count bits 6..0 give the position inside the 128-clock sub-cycle.
- R2: Take the active duty value D. Let C = D[7:1] and F = D[0]. Sub-cycle 0 is high for C+F clocks and sub-cycle 1 is high for C clocks.
- R3: Inside each sub-cycle the high clocks come first, at positions 0 up to the high count minus one, and the rest of the sub-cycle is low.
- R4: A written value goes into a shadow register. The shadow value held at the clock edge that ends count 255 becomes active for the whole next period, so a later write in the same period overrides an earlier one, and a period never mixes two values.
- R5: Duty 0x00 gives a constant low output. Duty 0xFF gives 128 high clocks in sub-cycle 0 and 127 high clocks in sub-cycle 1.
- R6: With PWM selected (`pwm_sel`=1) and the direction set to output (`pin_dir`=0), `pin_out` follows the waveform when `pin_data`=1 and is held low when `pin_data`=0.
- R7: With `pin_dir`=1 (input) both `pin_oe` and `pin_out` are 0, in either function mode.
- R8: With general I/O selected (`pwm_sel`=0) and `pin_dir`=0, `pin_out` equals `pin_data` and `pin_oe` is 1.
- R9: A synchronous reset clears the shadow and active duty values to 0, so the PWM output is low until a new value has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_wr | input | 1 | Write strobe for the duty shadow register |
| duty_wdata | input | 8 | Duty value to write |
| pwm_sel | input | 1 | 1 selects the PWM function, 0 selects general I/O |
| pin_dir | input | 1 | 1 sets the pin as an input (driver off), 0 as an output |
| pin_data | input | 1 | Gate bit in PWM mode, driven level in I/O mode |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardest situation to reach is a write that lands exactly on a period boundary. This covers a write during count 255, a write during count 0, and two writes in one period. In these cases the active value is decided by a single clock edge. The bench keeps its own model of the period position, steps to these exact counts, and issues the writes there. It then compares every clock of the following periods through the scoreboard, so a load that comes one cycle early or late shows up as a mismatched high clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        DIR_OUTPUT = 1'b0,
        DIR_INPUT  = 1'b1
    } pin_dir_e;

    typedef struct packed {
        logic oe;
        logic level;
    } pin_drive_t;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DUTY_W-1:0] wdata,
    output logic [DUTY_W-1:0] cnt,
    output logic [DUTY_W-1:0] act
);
    localparam logic [DUTY_W-1:0] LAST = '1;

    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        logic [DUTY_W-1:0] shadow;
        logic [DUTY_W-1:0] act;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (st_q.cnt == LAST) begin
            st_d.act = st_q.shadow;
        end
        if (wr) begin
            st_d.shadow = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign act = st_q.act;

endmodule

// File: rtl/pwm_shape.sv
module pwm_shape #(
    parameter int DUTY_W = 8,
    parameter int FINE_W = 1
) (
    input  logic [DUTY_W-1:0] cnt,
    input  logic [DUTY_W-1:0] act,
    output logic              wave
);
    localparam int POS_W = DUTY_W - FINE_W;

    logic [FINE_W-1:0] sub_idx;
    logic [FINE_W-1:0] fine_val;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  coarse;
    logic              extra;
    logic [POS_W:0]    high_len;

    always_comb begin
        sub_idx  = cnt[DUTY_W-1 -: FINE_W];
        pos      = cnt[POS_W-1:0];
        fine_val = act[FINE_W-1:0];
        coarse   = act[DUTY_W-1 -: POS_W];
        extra    = (sub_idx < fine_val);
        high_len = {1'b0, coarse} + {{POS_W{1'b0}}, extra};
        wave     = ({1'b0, pos} < high_len);
    end

endmodule

// File: rtl/pwm_pin.sv
module pwm_pin
    import pwm_pkg::*;
(
    input  logic pwm_sel,
    input  logic pin_dir,
    input  logic pin_data,
    input  logic wave,
    output logic pin_out,
    output logic pin_oe
);
    pin_drive_t drv;

    always_comb begin
        drv = '0;
        if (pin_dir_e'(pin_dir) == DIR_OUTPUT) begin
            drv.oe    = 1'b1;
            drv.level = pwm_sel ? (pin_data & wave) : pin_data;
        end
    end

    assign pin_out = drv.level;
    assign pin_oe  = drv.oe;

endmodule

// File: rtl/subcycle_pwm.sv
module subcycle_pwm #(
    parameter int DUTY_W = 8,
    parameter int FINE_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_wdata,
    input  logic              pwm_sel,
    input  logic              pin_dir,
    input  logic              pin_data,
    output logic              pin_out,
    output logic              pin_oe
);
    logic [DUTY_W-1:0] cnt;
    logic [DUTY_W-1:0] act;
    logic              wave;

    pwm_timebase #(.DUTY_W(DUTY_W)) u_timebase (
        .clk   (clk),
        .rst   (rst),
        .wr    (duty_wr),
        .wdata (duty_wdata),
        .cnt   (cnt),
        .act   (act)
    );

    pwm_shape #(.DUTY_W(DUTY_W), .FINE_W(FINE_W)) u_shape (
        .cnt  (cnt),
        .act  (act),
        .wave (wave)
    );

    pwm_pin u_pin (
        .pwm_sel  (pwm_sel),
        .pin_dir  (pin_dir),
        .pin_data (pin_data),
        .wave     (wave),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
    parameter int DUTY_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DUTY_W-1:0] cnt,
    input logic [DUTY_W-1:0] act,
    input logic              pwm_sel,
    input logic              pin_dir,
    input logic              pin_data,
    input logic              pin_out,
    input logic              pin_oe
);
    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cnt == DUTY_W'($past(cnt) + 1'b1));

    assert_load_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(act));

    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (rst)
        (act == '0 && pwm_sel) |-> !pin_out);

    assert_gate_off_R6: assert property (@(posedge clk) disable iff (rst)
        (pwm_sel && !pin_dir && !pin_data) |-> !pin_out);

    assert_input_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
        pin_dir |-> (!pin_oe && !pin_out));

    assert_gpio_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (!pwm_sel && !pin_dir) |-> (pin_oe && pin_out == pin_data));

    assert_reset_clears_R9: assert property (@(posedge clk)
        $past(rst) |-> (act == '0 && cnt == '0));

endmodule

bind subcycle_pwm pwm_checker #(.DUTY_W(DUTY_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt),
    .act      (act),
    .pwm_sel  (pwm_sel),
    .pin_dir  (pin_dir),
    .pin_data (pin_data),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/tb_subcycle_pwm.sv
`timescale 1ns/1ps
module tb_subcycle_pwm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       duty_wr = 1'b0;
    logic [7:0] duty_wdata = 8'h00;
    logic       pwm_sel = 1'b1;
    logic       pin_dir = 1'b0;
    logic       pin_data = 1'b1;
    logic       pin_out, pin_oe;

    subcycle_pwm dut (
        .clk(clk), .rst(rst), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
        .pwm_sel(pwm_sel), .pin_dir(pin_dir), .pin_data(pin_data),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #4 clk = ~clk;

    // requested controls, applied by the driver at the next negative edge
    bit c_rst = 1'b1, c_sel = 1'b1, c_dir = 1'b0, c_data = 1'b1;
    bit push_en = 1'b0;
    bit done = 1'b0;
    int checks = 0;
    int errors = 0;

    // bench model of the period state
    int         m_cnt = 0;
    logic [7:0] m_sh = 8'h00;
    logic [7:0] m_act = 8'h00;

    logic [1:0] q_exp[$];
    string      q_tag[$];

    task automatic step(input bit wr, input logic [7:0] wd, input string tag);
        int  sub, pos, hl;
        bit  hi;
        logic [1:0] e;
        @(negedge clk);
        rst = c_rst; pwm_sel = c_sel; pin_dir = c_dir; pin_data = c_data;
        duty_wr = wr; duty_wdata = wd;
        if (push_en) begin
            sub = m_cnt / 128;
            pos = m_cnt % 128;
            hl  = int'(m_act[7:1]) + ((sub == 0 && m_act[0]) ? 1 : 0);
            hi  = (pos < hl);
            if (c_dir)      e = 2'b00;
            else if (c_sel) e = {1'b1, c_data & hi};
            else            e = {1'b1, c_data};
            q_exp.push_back(e);
            q_tag.push_back(tag);
        end
        if (c_rst) begin
            m_cnt = 0; m_sh = 8'h00; m_act = 8'h00;
        end else begin
            if (m_cnt == 255) m_act = m_sh;
            if (wr) m_sh = wd;
            m_cnt = (m_cnt + 1) % 256;
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
    endtask

    task automatic run_to(input int pos, input string tag);
        while (m_cnt != pos) step(1'b0, 8'h00, tag);
    endtask

    task automatic write_at(input int pos, input logic [7:0] v, input string tag);
        run_to(pos, tag);
        step(1'b1, v, tag);
    endtask

    // monitor: pops expected items and compares away from the clock edge
    always @(negedge clk) begin
        logic [1:0] e;
        string      t;
        #2;
        if (q_exp.size() > 0) begin
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({pin_oe, pin_out} !== e) begin
                errors++;
                $display("FAIL %s at t=%0t: {oe,out} actual %b expected %b", t, $time, {pin_oe, pin_out}, e);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        run(2, "R9");
        push_en = 1'b1;
        run(3, "R9");             // reset state: output low, driver on
        c_rst = 1'b0;
        run(300, "R9");           // nothing loaded yet: stays low
        write_at(100, 8'h55, "R4");
        run_to(0, "R4");          // rest of period still uses 0
        run(512, "R2");           // C=42, F=1
        write_at(10, 8'hFF, "R5");
        run_to(0, "R5");
        run(256, "R5");           // 128 / 127 high clocks
        write_at(5, 8'h00, "R5");
        run_to(0, "R5");
        run(256, "R5");
        write_at(200, 8'h80, "R2");
        run_to(0, "R2");
        run(256, "R2");           // 64 and 64
        write_at(255, 8'h81, "R4"); // write on the last count: not yet active
        run(256, "R4");           // still 0x80
        run(256, "R2");           // now 0x81: 65 and 64
        write_at(0, 8'h01, "R4"); // write on count 0
        run(256, "R4");
        run(256, "R3");           // one high clock at position 0 of sub-cycle 0
        write_at(30, 8'h20, "R4");
        write_at(60, 8'h07, "R4"); // later write wins
        run_to(0, "R4");
        run(256, "R3");
        c_data = 1'b0; run(256, "R6");
        c_data = 1'b1; run(128, "R6");
        c_dir = 1'b1;  run(256, "R7");
        c_sel = 1'b0;  run(64, "R7");
        c_dir = 1'b0;
        for (int k = 0; k < 40; k++) begin
            c_data = k[1] ^ k[0];
            run(3, "R8");
        end
        c_sel = 1'b1; c_data = 1'b1;
        write_at(40, 8'hF0, "R1");
        run(400, "R1");
        run_to(77, "R1");
        c_rst = 1'b1; run(2, "R9");  // reset mid-period clears everything
        c_rst = 1'b0;
        run(300, "R1");
        write_at(3, 8'h0B, "R1");
        run_to(0, "R1");
        run(512, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule